// File: doc/BRIEF.md
# Operand-Ready Issue Queue with Register Scoreboard

This block holds dispatched micro-ops until both of their source operands are available, then hands out the oldest one that is ready. It keeps one readiness bit per physical register. Dispatching a producer marks its destination register pending. A completion broadcast on the writeback port marks that register available again and wakes every held entry that reads it. Dependents are found by comparing the broadcast tag against every slot, not by walking per-register lists.

Each dispatched op carries two source tags, one destination tag, a sequence number, and a fixed-mapping flag for each operand. Fixed-mapped registers take no part in tracking. A source the renamer already knows to be available can be flagged ready on dispatch. Otherwise the scoreboard is checked at insertion, with a same-cycle writeback bypassed in, so an operand that completed while the op was in flight is not missed. A squash port drops every op younger than a given sequence number. A one-cycle error pulse reports a producer dispatched onto a tag that held entries are still waiting for.

Top module: `sb_issue_queue`

## Requirements
- R1: After reset every scoreboard bit reads 1 (ready), no slot is valid, and `ready_vec`, `full`, `issue_valid`, `wake_count` and `dep_error` are all 0.
- R2: An accepted dispatch whose destination is not fixed-mapped sets that register's `sb_ready` bit to 0 at the next edge. When it hits the same register as a same-cycle writeback, the clear wins.
- R3: A writeback with `wb_fixed`=0 sets `sb_ready[wb_tag]` and marks ready every waiting source with that tag, so that no held source is left waiting on it. For that cycle, `wake_count` is the number of slots that had at least one source woken. In cycles without such a writeback it is 0.
- R4: On insertion, a source is stored as ready if its dispatch ready flag is set, if its scoreboard bit is 1, or if a non-fixed writeback of the same tag occurs in the same cycle. Otherwise it waits.
- R5: Fixed-mapped sources are always stored as ready. A fixed-mapped destination or writeback leaves the scoreboard unchanged, and a fixed writeback wakes nothing (`wake_count` 0).
- R6: Bit i of `ready_vec` is 1 exactly when slot i holds an op whose two sources are both ready.
- R7: Each cycle without a squash, the ready op with the smallest sequence number is issued and its slot freed. It appears at the next edge on `issue_valid`/`issue_seq`/`issue_dst_tag`. At most one op issues per cycle, and none issues in a squash cycle.
- R8: A squash removes, in one cycle, every held op whose sequence number is greater than `squash_seq`. A same-cycle dispatch with a greater sequence number is dropped. Ops with an equal or smaller number are kept.
- R9: `full` is 1 while every slot is valid, and a dispatch presented while `full` is 1 is ignored.
- R10: `dep_error` pulses for one cycle after an accepted dispatch of a non-fixed destination tag that some held op still waits on and that is not woken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_seq | input | SEQ_W | Sequence number of the dispatched op (larger is younger) |
| disp_src0_tag | input | TAG_W | First source register |
| disp_src0_fixed | input | 1 | First source is fixed-mapped |
| disp_src0_rdy | input | 1 | First source already known ready |
| disp_src1_tag | input | TAG_W | Second source register |
| disp_src1_fixed | input | 1 | Second source is fixed-mapped |
| disp_src1_rdy | input | 1 | Second source already known ready |
| disp_dst_tag | input | TAG_W | Destination register |
| disp_dst_fixed | input | 1 | Destination is fixed-mapped |
| full | output | 1 | All slots occupied; dispatch stalls |
| wb_valid | input | 1 | Completion broadcast |
| wb_tag | input | TAG_W | Completed destination register |
| wb_fixed | input | 1 | Completed register is fixed-mapped |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Ops younger than this are removed |
| ready_vec | output | ENTRIES | Per-slot all-operands-ready flags |
| issue_valid | output | 1 | An op was issued |
| issue_seq | output | SEQ_W | Sequence number of the issued op |
| issue_dst_tag | output | TAG_W | Destination of the issued op |
| wake_count | output | clog2(ENTRIES+1) | Slots woken by the last cycle's writeback |
| dep_error | output | 1 | Producer dispatched onto a tag with waiting consumers |
| sb_ready | output | 2**TAG_W | Scoreboard readiness bits |

## Verification
The assertions assume that sequence numbers grow monotonically and do not wrap while ops are held, because age is compared as plain unsigned values. They also assume that the fixed flag of a writeback matches the flag its producer carried. The stimulus numbers ops in increasing order well below the wrap point and always sends fixed writebacks with `wb_fixed` set. It never dispatches a non-fixed producer during a squash, which keeps the scoreboard-clear property free of the dropped-dispatch case.

// File: rtl/iq_pkg.sv
package iq_pkg;
  parameter int TAG_W = 5;
  parameter int SEQ_W = 8;

  typedef struct packed {
    logic             valid;
    logic [SEQ_W-1:0] seq;
    logic [TAG_W-1:0] s0_tag;
    logic             s0_rdy;
    logic [TAG_W-1:0] s1_tag;
    logic             s1_rdy;
    logic [TAG_W-1:0] dst_tag;
  } iq_slot_t;
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
  parameter int TAG_W = 5,
  localparam int NREGS = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  output logic [NREGS-1:0] bits
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '1;
    end else begin
      if (set_en) bits[set_tag] <= 1'b1;
      // a new producer overrides a completion of the same register
      if (clr_en) bits[clr_tag] <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_slot.sv
module iq_slot
  import iq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  iq_slot_t         load_e,
  input  logic             wb_en,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             kill,
  input  logic             free,
  output iq_slot_t         e,
  output logic             woke
);
  logic hit0, hit1;

  always_comb begin
    hit0 = wb_en && e.valid && !e.s0_rdy && (e.s0_tag == wb_tag);
    hit1 = wb_en && e.valid && !e.s1_rdy && (e.s1_tag == wb_tag);
    woke = hit0 || hit1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e <= '0;
    end else if (load) begin
      e <= load_e;
    end else if (kill || free) begin
      e.valid <= 1'b0;
    end else begin
      if (hit0) e.s0_rdy <= 1'b1;
      if (hit1) e.s1_rdy <= 1'b1;
    end
  end
endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick #(
  parameter int N     = 8,
  parameter int SEQ_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            req,
  input  logic [N-1:0][SEQ_W-1:0] seq,
  output logic                    found,
  output logic [IDX_W-1:0]        idx
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || seq[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = seq[i];
      end
    end
  end
endmodule

// File: rtl/sb_issue_queue.sv
module sb_issue_queue
  import iq_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int NREGS = 1 << TAG_W,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               disp_valid,
  input  logic [SEQ_W-1:0]   disp_seq,
  input  logic [TAG_W-1:0]   disp_src0_tag,
  input  logic               disp_src0_fixed,
  input  logic               disp_src0_rdy,
  input  logic [TAG_W-1:0]   disp_src1_tag,
  input  logic               disp_src1_fixed,
  input  logic               disp_src1_rdy,
  input  logic [TAG_W-1:0]   disp_dst_tag,
  input  logic               disp_dst_fixed,
  output logic               full,
  input  logic               wb_valid,
  input  logic [TAG_W-1:0]   wb_tag,
  input  logic               wb_fixed,
  input  logic               squash_valid,
  input  logic [SEQ_W-1:0]   squash_seq,
  output logic [ENTRIES-1:0] ready_vec,
  output logic               issue_valid,
  output logic [SEQ_W-1:0]   issue_seq,
  output logic [TAG_W-1:0]   issue_dst_tag,
  output logic [CNT_W-1:0]   wake_count,
  output logic               dep_error,
  output logic [NREGS-1:0]   sb_ready
);
  iq_slot_t [ENTRIES-1:0]            slots;
  logic [ENTRIES-1:0]                woke, load, kill, free;
  logic [ENTRIES-1:0][SEQ_W-1:0]     seqs;
  logic                              wb_live, accept, pend, pick_found, issue_go;
  logic [IDX_W-1:0]                  free_idx, pick_idx;
  logic                              free_found;
  logic [CNT_W-1:0]                  woke_n;
  iq_slot_t                          new_e;

  assign wb_live = wb_valid && !wb_fixed;

  always_comb begin
    full = 1'b1;
    for (int i = 0; i < ENTRIES; i++) full &= slots[i].valid;
  end

  assign accept = disp_valid && !full &&
                  !(squash_valid && disp_seq > squash_seq);

  iq_scoreboard #(.TAG_W(TAG_W)) u_sb (
    .clk     (clk),
    .rst     (rst),
    .set_en  (wb_live),
    .set_tag (wb_tag),
    .clr_en  (accept && !disp_dst_fixed),
    .clr_tag (disp_dst_tag),
    .bits    (sb_ready)
  );

  // insertion lookup with same-cycle completion bypass
  always_comb begin
    new_e         = '0;
    new_e.valid   = 1'b1;
    new_e.seq     = disp_seq;
    new_e.s0_tag  = disp_src0_tag;
    new_e.s1_tag  = disp_src1_tag;
    new_e.dst_tag = disp_dst_tag;
    new_e.s0_rdy  = disp_src0_rdy || disp_src0_fixed || sb_ready[disp_src0_tag] ||
                    (wb_live && wb_tag == disp_src0_tag);
    new_e.s1_rdy  = disp_src1_rdy || disp_src1_fixed || sb_ready[disp_src1_tag] ||
                    (wb_live && wb_tag == disp_src1_tag);
  end

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    pend       = 1'b0;
    woke_n     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!slots[i].valid && !free_found) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (slots[i].valid &&
          ((!slots[i].s0_rdy && slots[i].s0_tag == disp_dst_tag) ||
           (!slots[i].s1_rdy && slots[i].s1_tag == disp_dst_tag)))
        pend = 1'b1;
      woke_n += CNT_W'(woke[i]);
    end
  end

  iq_oldest_pick #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_pick (
    .req   (ready_vec),
    .seq   (seqs),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign issue_go = pick_found && !squash_valid;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign load[g]      = accept && free_found && (free_idx == IDX_W'(g));
    assign kill[g]      = squash_valid && slots[g].valid && (slots[g].seq > squash_seq);
    assign free[g]      = issue_go && (pick_idx == IDX_W'(g));
    assign seqs[g]      = slots[g].seq;
    assign ready_vec[g] = slots[g].valid && slots[g].s0_rdy && slots[g].s1_rdy;

    iq_slot u_slot (
      .clk    (clk),
      .rst    (rst),
      .load   (load[g]),
      .load_e (new_e),
      .wb_en  (wb_live),
      .wb_tag (wb_tag),
      .kill   (kill[g]),
      .free   (free[g]),
      .e      (slots[g]),
      .woke   (woke[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid   <= 1'b0;
      issue_seq     <= '0;
      issue_dst_tag <= '0;
      wake_count    <= '0;
      dep_error     <= 1'b0;
    end else begin
      issue_valid   <= issue_go;
      issue_seq     <= slots[pick_idx].seq;
      issue_dst_tag <= slots[pick_idx].dst_tag;
      wake_count    <= wb_live ? woke_n : '0;
      dep_error     <= accept && !disp_dst_fixed && pend &&
                       !(wb_live && wb_tag == disp_dst_tag);
    end
  end
endmodule

// File: rtl/sb_issue_queue_chk.sv
module sb_issue_queue_chk
  import iq_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int NREGS = 1 << TAG_W,
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               disp_valid,
  input logic [TAG_W-1:0]   disp_dst_tag,
  input logic               disp_dst_fixed,
  input logic               full,
  input logic               wb_valid,
  input logic [TAG_W-1:0]   wb_tag,
  input logic               wb_fixed,
  input logic               squash_valid,
  input logic [ENTRIES-1:0] ready_vec,
  input logic               issue_valid,
  input logic [CNT_W-1:0]   wake_count,
  input logic               dep_error,
  input logic [NREGS-1:0]   sb_ready
);
  a_r2_disp_clears: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !full && !disp_dst_fixed && !squash_valid)
      |=> !sb_ready[$past(disp_dst_tag)]);

  a_r3_wb_sets: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_fixed &&
     !(disp_valid && !full && !disp_dst_fixed && disp_dst_tag == wb_tag))
      |=> sb_ready[$past(wb_tag)]);

  a_r3_no_wake_idle: assert property (@(posedge clk) disable iff (rst)
    !(wb_valid && !wb_fixed) |=> (wake_count == '0));

  a_r6_issue_needs_ready: assert property (@(posedge clk) disable iff (rst)
    (ready_vec == '0) |=> !issue_valid);

  a_r7_no_issue_on_squash: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> !issue_valid);

  a_r10_err_needs_disp: assert property (@(posedge clk) disable iff (rst)
    !disp_valid |=> !dep_error);
endmodule

bind sb_issue_queue sb_issue_queue_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .disp_valid     (disp_valid),
  .disp_dst_tag   (disp_dst_tag),
  .disp_dst_fixed (disp_dst_fixed),
  .full           (full),
  .wb_valid       (wb_valid),
  .wb_tag         (wb_tag),
  .wb_fixed       (wb_fixed),
  .squash_valid   (squash_valid),
  .ready_vec      (ready_vec),
  .issue_valid    (issue_valid),
  .wake_count     (wake_count),
  .dep_error      (dep_error),
  .sb_ready       (sb_ready)
);

// File: tb/sb_issue_queue_test.sv
`timescale 1ns/1ps
module sb_issue_queue_test;
  import iq_pkg::*;
  localparam int ENTRIES = 8;
  localparam int NREGS = 1 << TAG_W;
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_valid, disp_src0_fixed, disp_src0_rdy, disp_src1_fixed, disp_src1_rdy, disp_dst_fixed;
  logic [SEQ_W-1:0] disp_seq, squash_seq, issue_seq;
  logic [TAG_W-1:0] disp_src0_tag, disp_src1_tag, disp_dst_tag, wb_tag, issue_dst_tag;
  logic full, wb_valid, wb_fixed, squash_valid, issue_valid, dep_error;
  logic [ENTRIES-1:0] ready_vec;
  logic [CNT_W-1:0] wake_count;
  logic [NREGS-1:0] sb_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sb_issue_queue #(.ENTRIES(ENTRIES)) uut (.*);

  typedef struct packed {
    logic       dv;
    logic [7:0] seq;
    logic [4:0] s0;
    logic [4:0] s1;
    logic [4:0] dst;
    logic       wv;
    logic [4:0] wt;
    logic [7:0] erdy;
    logic       eiv;
    logic [7:0] eiseq;
    logic [3:0] ewake;
  } vec_t;

  // one row per cycle; expectations sampled after that cycle's edge
  localparam vec_t TBL [8] = '{
    '{1'b1, 8'd1, 5'd1,  5'd2,  5'd10, 1'b0, 5'd0,  8'h01, 1'b0, 8'd0, 4'd0},
    '{1'b1, 8'd2, 5'd10, 5'd3,  5'd11, 1'b0, 5'd0,  8'h00, 1'b1, 8'd1, 4'd0},
    '{1'b1, 8'd3, 5'd11, 5'd10, 5'd12, 1'b0, 5'd0,  8'h00, 1'b0, 8'd0, 4'd0},
    '{1'b0, 8'd0, 5'd0,  5'd0,  5'd0,  1'b1, 5'd10, 8'h02, 1'b0, 8'd0, 4'd2},
    '{1'b0, 8'd0, 5'd0,  5'd0,  5'd0,  1'b0, 5'd0,  8'h00, 1'b1, 8'd2, 4'd0},
    '{1'b1, 8'd4, 5'd11, 5'd5,  5'd13, 1'b1, 5'd11, 8'h03, 1'b0, 8'd0, 4'd1},
    '{1'b0, 8'd0, 5'd0,  5'd0,  5'd0,  1'b0, 5'd0,  8'h02, 1'b1, 8'd3, 4'd0},
    '{1'b0, 8'd0, 5'd0,  5'd0,  5'd0,  1'b0, 5'd0,  8'h00, 1'b1, 8'd4, 4'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_seq = 0;
    disp_src0_tag = 0; disp_src0_fixed = 0; disp_src0_rdy = 0;
    disp_src1_tag = 0; disp_src1_fixed = 0; disp_src1_rdy = 0;
    disp_dst_tag = 0; disp_dst_fixed = 0;
    wb_valid = 0; wb_tag = 0; wb_fixed = 0;
    squash_valid = 0; squash_seq = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic disp(input int seq, input int s0, input int s1, input int dst);
    disp_valid = 1; disp_seq = SEQ_W'(seq);
    disp_src0_tag = TAG_W'(s0); disp_src1_tag = TAG_W'(s1); disp_dst_tag = TAG_W'(dst);
  endtask

  task automatic wb(input int tag);
    wb_valid = 1; wb_tag = TAG_W'(tag);
  endtask

  initial begin
    idle();
    @(negedge clk); tick(); tick();
    rst = 0;
    // R1 reset state
    check("R1 sb_ready", sb_ready, '1);
    check("R1 ready_vec", 32'(ready_vec), 0);
    check("R1 full", 32'(full), 0);
    check("R1 issue_valid", 32'(issue_valid), 0);
    check("R1 wake_count", 32'(wake_count), 0);
    check("R1 dep_error", 32'(dep_error), 0);

    // table: R3 wakeup, R4 bypass, R6 ready, R7 oldest issue
    for (int i = 0; i < 8; i++) begin
      idle();
      disp_valid = TBL[i].dv; disp_seq = TBL[i].seq;
      disp_src0_tag = TBL[i].s0; disp_src1_tag = TBL[i].s1; disp_dst_tag = TBL[i].dst;
      wb_valid = TBL[i].wv; wb_tag = TBL[i].wt;
      tick();
      check($sformatf("R6 ready_vec row %0d", i), 32'(ready_vec), 32'(TBL[i].erdy));
      check($sformatf("R7 issue_valid row %0d", i), 32'(issue_valid), 32'(TBL[i].eiv));
      if (TBL[i].eiv) check($sformatf("R7 issue_seq row %0d", i), 32'(issue_seq), 32'(TBL[i].eiseq));
      check($sformatf("R3 wake_count row %0d", i), 32'(wake_count), 32'(TBL[i].ewake));
    end
    // R2 producers cleared their registers, R3 completions set them
    check("R3 sb[10]", 32'(sb_ready[10]), 1);
    check("R3 sb[11]", 32'(sb_ready[11]), 1);
    check("R2 sb[12]", 32'(sb_ready[12]), 0);
    check("R2 sb[13]", 32'(sb_ready[13]), 0);

    // R5 fixed-mapped source, destination and writeback
    idle(); disp(10, 12, 1, 13); disp_src0_fixed = 1; disp_dst_fixed = 1;
    wb(12); wb_fixed = 1;
    tick();
    check("R5 fixed src ready", 32'(ready_vec), 32'h01);
    check("R5 sb[12] kept", 32'(sb_ready[12]), 0);
    check("R5 sb[13] kept", 32'(sb_ready[13]), 0);
    check("R5 fixed wb wakes none", 32'(wake_count), 0);
    idle(); tick();
    check("R7 fixed op issues", 32'(issue_seq), 10);

    // R10 producer dispatched over a waiting consumer
    idle(); disp(20, 12, 1, 14); tick();
    idle(); disp(21, 1, 2, 12); tick();
    check("R10 dep_error set", 32'(dep_error), 1);
    idle(); tick();
    check("R10 dep_error pulse", 32'(dep_error), 0);
    check("R7 issue seq21", 32'(issue_seq), 21);
    idle(); wb(12); tick();
    check("R3 wake one", 32'(wake_count), 1);
    idle(); tick();
    check("R7 issue seq20", 32'(issue_seq), 20);

    // R8 squash of younger ops and of a same-cycle dispatch
    idle(); disp(29, 1, 2, 15); tick();
    idle(); disp(30, 15, 1, 17); tick();
    idle(); disp(31, 15, 1, 18); tick();
    idle(); disp(32, 1, 15, 19); tick();
    idle(); disp(33, 15, 2, 20); disp_dst_fixed = 1;
    squash_valid = 1; squash_seq = 30; tick();
    check("R8 no issue in squash", 32'(issue_valid), 0);
    idle(); wb(15); tick();
    check("R8 only kept op woken", 32'(wake_count), 1);
    idle(); tick();
    check("R8 kept op issues", 32'(issue_seq), 30);
    idle(); tick();
    check("R8 nothing left", 32'(issue_valid), 0);

    // R9 full, ignored dispatch, and R7 age order across slots
    idle(); disp(45, 1, 2, 16); tick();
    begin
      int sq [8] = '{50, 57, 52, 55, 51, 56, 53, 54};
      for (int i = 0; i < 8; i++) begin
        idle(); disp(sq[i], 16, 1, 21); tick();
      end
    end
    check("R9 full set", 32'(full), 1);
    idle(); disp(40, 1, 2, 22); disp_dst_fixed = 1; tick();
    check("R9 dispatch ignored", 32'(ready_vec), 0);
    idle(); wb(16); tick();
    check("R3 wake all", 32'(wake_count), 8);
    check("R6 all ready", 32'(ready_vec), 32'hFF);
    for (int i = 0; i < 8; i++) begin
      idle(); tick();
      check($sformatf("R7 order %0d", i), 32'(issue_seq), 32'(50 + i));
    end
    check("R9 full clear", 32'(full), 0);
    idle(); tick();
    check("R9 ignored op never issues", 32'(issue_valid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule